// File: doc/BRIEF.md
# Dual Maskable Calendar Alarm

This block watches the running clock and calendar and raises an alarm when the time matches a programmed value. The current seconds, minutes, hours, date, month and day-of-week arrive as parallel inputs. A one-cycle `tick` marks each new second. The block holds a parameterised number of alarm units, two by default, and the units are independent of each other. Each unit stores a target value for every field and a per-field enable mask. A field whose enable bit is clear is a wildcard. With a sparse mask an alarm can fire once a minute, on every Tuesday, or at one exact minute of one exact day.

Each unit has two states. In `ST_IDLE` the unit is disarmed. In `ST_ARMED` it compares the fields on every tick. The transitions are:
- **arm**: `ST_IDLE` to `ST_ARMED`, when software writes the control register with the arm bit set.
- **disarm**: `ST_ARMED` to `ST_IDLE`, when software writes the control register with the arm bit clear.
- **one-shot**: `ST_ARMED` to `ST_IDLE`, when a match fires while repeat is off.
- **repeat hold**: `ST_ARMED` stays in `ST_ARMED`, when a match fires while repeat is on.

A match sets a sticky per-unit flag. Software can poll the flag through the register port. When the unit's interrupt enable is set, the flag also pulls the shared active-low interrupt line low.

Software reaches the registers through a parallel port. The upper address bits select the unit and the low three bits select the register inside it:
- 0 to 5: target for seconds, minutes, hours, date, month and day-of-week.
- 6: control. Bits 5:0 are the field enables in the same field order, bit 6 is repeat, and bit 7 is the arm bit (it reads back the state).
- 7: status. Bit 0 is the flag (write 1 to clear), and bit 1 is the interrupt enable.

Top module: `alarm_pair`

## Requirements
- R1: After reset every register reads zero, both flags are 0, `irq_n` is 1, and both units are in `ST_IDLE`.
- R2: An armed unit sets its flag at the clock edge that samples `tick`=1 when every enabled field equals the current field. Without `tick`, no flag is set.
- R3: A field whose enable bit (control bits 5:0, in the order seconds, minutes, hours, date, month, day-of-week) is 0 does not take part in the comparison.
- R4: A unit whose six field enables are all 0 never sets its flag, even while armed.
- R5: With repeat (control bit 6) at 0, a firing returns the unit to `ST_IDLE`: control bit 7 reads 0 and later matching ticks set nothing. This happens unless the same edge writes the control register, and then the written arm bit wins.
- R6: With repeat at 1, the unit stays in `ST_ARMED` after firing and sets its flag on every matching tick.
- R7: The flag holds until a write to status with bit 0 = 1 clears it. Writing bit 0 = 0 has no effect. A firing on the same edge as a clear leaves the flag set.
- R8: `irq_n` is 0 exactly when some unit has both its flag and its interrupt enable (status bit 1) set.
- R9: Writes and matches for one unit leave the other unit's registers and flag unchanged.
- R10: A unit in `ST_IDLE` never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second; the comparison is made only when it is high |
| cur_sec | input | 6 | Current seconds |
| cur_min | input | 6 | Current minutes |
| cur_hour | input | 5 | Current hours |
| cur_date | input | 5 | Current day of month |
| cur_month | input | 4 | Current month |
| cur_dow | input | 3 | Current day of week |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address: bit 3 selects the unit, bits 2:0 select the register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| alarm_flag | output | 2 | Sticky flag of each unit |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
Flags, the unit state and all register contents change at the clock edge that samples the tick or the write. They are therefore due one cycle after the inputs are driven. `irq_n` and `rd_data` are combinational from those registers and from `addr`, so they are also due in that same cycle. The bench drives every input on the falling edge and updates its model as of the following rising edge. It samples all outputs 1 ns after that rising edge, well before the next falling edge, so each comparison sees exactly one edge of effect.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HOUR_W  = 5;
    localparam int DATE_W  = 5;
    localparam int MONTH_W = 4;
    localparam int DOW_W   = 3;
    localparam int NFIELD  = 6;
    localparam int REG_W   = 3;

    // Register indices inside one unit; the field order matches the enable bit order.
    localparam logic [REG_W-1:0] REG_SEC   = 3'd0;
    localparam logic [REG_W-1:0] REG_MIN   = 3'd1;
    localparam logic [REG_W-1:0] REG_HOUR  = 3'd2;
    localparam logic [REG_W-1:0] REG_DATE  = 3'd3;
    localparam logic [REG_W-1:0] REG_MONTH = 3'd4;
    localparam logic [REG_W-1:0] REG_DOW   = 3'd5;
    localparam logic [REG_W-1:0] REG_CTRL  = 3'd6;
    localparam logic [REG_W-1:0] REG_STAT  = 3'd7;

    localparam int CTRL_REP  = 6;
    localparam int CTRL_ARM  = 7;
    localparam int STAT_FLAG = 0;
    localparam int STAT_IEN  = 1;

    typedef struct packed {
        logic [DOW_W-1:0]   dow;
        logic [MONTH_W-1:0] month;
        logic [DATE_W-1:0]  date;
        logic [HOUR_W-1:0]  hour;
        logic [MIN_W-1:0]   min;
        logic [SEC_W-1:0]   sec;
    } alm_time_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } alm_state_t;
endpackage

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
(
    input  alm_time_t         cur,
    input  alm_time_t         target,
    input  logic [NFIELD-1:0] field_en,
    output logic              hit
);
    logic [NFIELD-1:0] eq;

    always_comb begin
        eq[0] = (cur.sec   == target.sec);
        eq[1] = (cur.min   == target.min);
        eq[2] = (cur.hour  == target.hour);
        eq[3] = (cur.date  == target.date);
        eq[4] = (cur.month == target.month);
        eq[5] = (cur.dow   == target.dow);
    end

    // Masked fields always agree; an empty mask never hits.
    assign hit = (|field_en) && (&(eq | ~field_en));
endmodule

// File: rtl/alm_irq_merge.sv
module alm_irq_merge #(
    parameter int N_ALARMS = 2
) (
    input  logic [N_ALARMS-1:0] flags,
    input  logic [N_ALARMS-1:0] irq_en,
    output logic                irq_n
);
    assign irq_n = ~(|(flags & irq_en));
endmodule

// File: rtl/alm_unit.sv
module alm_unit
    import alm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  alm_time_t         cur,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              flag,
    output logic              irq_en
);
    alm_time_t         target_q;
    logic [NFIELD-1:0] fen_q;
    logic              rep_q;
    logic              ien_q;
    logic              flag_q;
    alm_state_t        state_q;
    alm_state_t        state_d;
    logic              hit;
    logic              fire;
    logic              ctrl_wr;
    logic              clr;

    alm_match u_match (
        .cur      (cur),
        .target   (target_q),
        .field_en (fen_q),
        .hit      (hit)
    );

    assign ctrl_wr = wr_en && (reg_sel == REG_CTRL);
    assign clr     = wr_en && (reg_sel == REG_STAT) && wr_data[STAT_FLAG];
    assign fire    = tick && (state_q == ST_ARMED) && hit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr && wr_data[CTRL_ARM]) state_d = ST_ARMED;        // arm
            end
            ST_ARMED: begin
                if (ctrl_wr)                state_d = wr_data[CTRL_ARM] ? ST_ARMED : ST_IDLE;
                else if (fire && !rep_q)    state_d = ST_IDLE;               // one-shot
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            fen_q    <= '0;
            rep_q    <= 1'b0;
            ien_q    <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_sel)
                REG_SEC:   target_q.sec   <= wr_data[SEC_W-1:0];
                REG_MIN:   target_q.min   <= wr_data[MIN_W-1:0];
                REG_HOUR:  target_q.hour  <= wr_data[HOUR_W-1:0];
                REG_DATE:  target_q.date  <= wr_data[DATE_W-1:0];
                REG_MONTH: target_q.month <= wr_data[MONTH_W-1:0];
                REG_DOW:   target_q.dow   <= wr_data[DOW_W-1:0];
                REG_CTRL: begin
                    fen_q <= wr_data[NFIELD-1:0];
                    rep_q <= wr_data[CTRL_REP];
                end
                REG_STAT:  ien_q <= wr_data[STAT_IEN];
                default: ;
            endcase
        end
    end

    // Sticky flag: a firing outranks a clear on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= fire | (flag_q & ~clr);
    end

    // Outputs
    always_comb begin
        flag    = flag_q;
        irq_en  = ien_q;
        rd_data = '0;
        unique case (reg_sel)
            REG_SEC:   rd_data = DATA_W'(target_q.sec);
            REG_MIN:   rd_data = DATA_W'(target_q.min);
            REG_HOUR:  rd_data = DATA_W'(target_q.hour);
            REG_DATE:  rd_data = DATA_W'(target_q.date);
            REG_MONTH: rd_data = DATA_W'(target_q.month);
            REG_DOW:   rd_data = DATA_W'(target_q.dow);
            REG_CTRL:  rd_data = DATA_W'({(state_q == ST_ARMED), rep_q, fen_q});
            REG_STAT:  rd_data = DATA_W'({ien_q, flag_q});
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/alarm_pair.sv
module alarm_pair
    import alm_pkg::*;
#(
    parameter  int N_ALARMS = 2,
    parameter  int DATA_W   = 8,
    localparam int SEL_W    = $clog2(N_ALARMS),
    localparam int ADDR_W   = SEL_W + REG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [SEC_W-1:0]    cur_sec,
    input  logic [MIN_W-1:0]    cur_min,
    input  logic [HOUR_W-1:0]   cur_hour,
    input  logic [DATE_W-1:0]   cur_date,
    input  logic [MONTH_W-1:0]  cur_month,
    input  logic [DOW_W-1:0]    cur_dow,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [N_ALARMS-1:0] alarm_flag,
    output logic                irq_n
);
    alm_time_t         cur;
    logic [SEL_W-1:0]  unit_sel;
    logic [REG_W-1:0]  reg_sel;
    logic [N_ALARMS-1:0] ien;
    logic [DATA_W-1:0] rd_arr [N_ALARMS];

    assign cur      = '{dow: cur_dow, month: cur_month, date: cur_date,
                        hour: cur_hour, min: cur_min, sec: cur_sec};
    assign unit_sel = addr[ADDR_W-1:REG_W];
    assign reg_sel  = addr[REG_W-1:0];

    for (genvar i = 0; i < N_ALARMS; i++) begin : g_unit
        alm_unit #(
            .DATA_W (DATA_W)
        ) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .cur     (cur),
            .wr_en   (wr_en && (unit_sel == SEL_W'(i))),
            .reg_sel (reg_sel),
            .wr_data (wr_data),
            .rd_data (rd_arr[i]),
            .flag    (alarm_flag[i]),
            .irq_en  (ien[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_ALARMS; k++) begin
            if (unit_sel == SEL_W'(k)) rd_data = rd_arr[k];
        end
    end

    alm_irq_merge #(
        .N_ALARMS (N_ALARMS)
    ) u_irq (
        .flags  (alarm_flag),
        .irq_en (ien),
        .irq_n  (irq_n)
    );
endmodule

// File: rtl/alm_pair_chk.sv
module alm_pair_chk #(
    parameter int N_ALARMS = 2,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [N_ALARMS-1:0] alarm_flag,
    input logic                irq_n
);
    localparam logic [ADDR_W-1:0] STAT0 = ADDR_W'(7);

    // A flag can only appear at the edge after a tick
    assert_flag_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(alarm_flag & ~$past(alarm_flag))) |-> $past(tick));

    // Clearing with no tick present empties unit 0's flag
    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == STAT0 && wr_data[0] && !tick) |=> !alarm_flag[0]);

    // Without a clear, unit 0's flag stays set
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag[0] && !(wr_en && addr == STAT0 && wr_data[0])) |=> alarm_flag[0]);

    // Interrupt low only with some flag set
    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|alarm_flag));

    // No flags means the interrupt is idle
    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag == '0) |-> irq_n);
endmodule

bind alarm_pair alm_pair_chk #(
    .N_ALARMS (N_ALARMS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .alarm_flag (alarm_flag),
    .irq_n      (irq_n)
);

// File: tb/alarm_pair_test.sv
module alarm_pair_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [5:0] cur_sec, cur_min;
    logic [4:0] cur_hour, cur_date;
    logic [3:0] cur_month;
    logic [2:0] cur_dow;
    logic       wr_en;
    logic [3:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [1:0] alarm_flag;
    logic       irq_n;

    int errors = 0;
    int checks = 0;

    // Model state
    int         m_val [2][6];
    logic [5:0] m_en  [2];
    logic       m_rep [2];
    logic       m_arm [2];
    logic       m_ien [2];
    logic       m_flag[2];
    int         cur   [6];

    always #2 clk = ~clk;

    alarm_pair uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_month(cur_month), .cur_dow(cur_dow),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    function automatic int fmask(int r);
        case (r)
            0, 1:    return 63;
            2, 3:    return 31;
            4:       return 15;
            default: return 7;
        endcase
    endfunction

    function automatic logic mfire(int a, logic tk);
        if (!tk || !m_arm[a] || m_en[a] == 6'd0) return 1'b0;
        for (int f = 0; f < 6; f++)
            if (m_en[a][f] && cur[f] != m_val[a][f]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [7:0] mread(logic [3:0] ad);
        int a = ad[3];
        int r = ad[2:0];
        if (r < 6)  return 8'(m_val[a][r]);
        if (r == 6) return {m_arm[a], m_rep[a], m_en[a]};
        return {6'd0, m_ien[a], m_flag[a]};
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_cur(int s, int mi, int h, int d, int mo, int w);
        cur[0] = s; cur[1] = mi; cur[2] = h; cur[3] = d; cur[4] = mo; cur[5] = w;
    endtask

    task automatic step(string tag, logic tk, logic we, logic [3:0] ad, logic [7:0] wd);
        logic fire [2];
        int   a_sel;
        int   r;
        logic clr, ctrlw;
        @(negedge clk);
        cur_sec = 6'(cur[0]); cur_min = 6'(cur[1]); cur_hour = 5'(cur[2]);
        cur_date = 5'(cur[3]); cur_month = 4'(cur[4]); cur_dow = 3'(cur[5]);
        tick = tk; wr_en = we; addr = ad; wr_data = wd;
        for (int a = 0; a < 2; a++) fire[a] = mfire(a, tk);
        @(posedge clk);
        #1;
        a_sel = ad[3];
        r     = ad[2:0];
        for (int a = 0; a < 2; a++) begin
            clr   = we && a_sel == a && r == 7 && wd[0];
            ctrlw = we && a_sel == a && r == 6;
            m_flag[a] = fire[a] | (m_flag[a] & ~clr);
            if (we && a_sel == a) begin
                if (r < 6) m_val[a][r] = int'(wd) & fmask(r);
                else if (r == 6) begin m_en[a] = wd[5:0]; m_rep[a] = wd[6]; end
                else m_ien[a] = wd[1];
            end
            m_arm[a] = ctrlw ? wd[7] : ((fire[a] && !m_rep[a]) ? 1'b0 : m_arm[a]);
        end
        check(tag, "flag0", int'(alarm_flag[0]), int'(m_flag[0]));
        check(tag, "flag1 (R9)", int'(alarm_flag[1]), int'(m_flag[1]));
        check("R8", "irq_n", int'(irq_n),
              int'(!((m_flag[0] & m_ien[0]) | (m_flag[1] & m_ien[1]))));
        check(tag, "rd_data", int'(rd_data), int'(mread(ad)));
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int a = 0; a < 2; a++) begin
            for (int f = 0; f < 6; f++) m_val[a][f] = 0;
            m_en[a] = '0; m_rep[a] = 0; m_arm[a] = 0; m_ien[a] = 0; m_flag[a] = 0;
        end
        set_cur(0, 0, 0, 0, 0, 0);
        rst_n = 1'b0; tick = 0; wr_en = 0; addr = 0; wr_data = 0;
        cur_sec = 0; cur_min = 0; cur_hour = 0; cur_date = 0; cur_month = 0; cur_dow = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step("R1", 0, 0, 4'h6, 8'h00);
        step("R1", 0, 0, 4'hF, 8'h00);
        step("R1", 0, 0, 4'h0, 8'h00);

        // R2/R3/R5: one-shot at sec 30, min 15, hour 5; date masked
        step("R2", 0, 1, 4'h0, 8'd30);
        step("R2", 0, 1, 4'h1, 8'd15);
        step("R2", 0, 1, 4'h2, 8'd5);
        step("R3", 0, 1, 4'h3, 8'd9);
        step("R2", 0, 1, 4'h6, 8'h87);
        set_cur(30, 15, 5, 20, 3, 2);
        step("R2", 0, 0, 4'h6, 8'h00);          // no tick, no flag
        step("R3", 1, 0, 4'h6, 8'h00);          // fires despite date mismatch
        step("R5", 1, 0, 4'h6, 8'h00);          // disarmed, arm bit reads 0
        step("R7", 0, 1, 4'h7, 8'h00);          // write 0 keeps the flag
        step("R7", 0, 1, 4'h7, 8'h01);          // clear
        step("R5", 1, 0, 4'h7, 8'h00);          // no refire after one-shot

        // R6: repeat on seconds only
        step("R6", 0, 1, 4'h6, 8'hC1);
        set_cur(30, 40, 22, 1, 7, 6);
        step("R6", 1, 0, 4'h6, 8'h00);
        step("R7", 1, 1, 4'h7, 8'h01);          // set beats clear
        step("R7", 0, 1, 4'h7, 8'h01);
        step("R6", 1, 0, 4'h6, 8'h00);          // still armed, fires again
        step("R6", 0, 1, 4'h6, 8'h00);          // disarm
        step("R7", 0, 1, 4'h7, 8'h01);

        // R4: armed with empty mask
        set_cur(0, 0, 0, 0, 0, 0);
        step("R4", 0, 1, 4'hE, 8'h80);
        step("R4", 1, 0, 4'hF, 8'h00);

        // R10: enabled field but not armed
        step("R10", 0, 1, 4'hE, 8'h01);
        step("R10", 1, 0, 4'hF, 8'h00);

        // R8/R9: unit 1 interrupts, unit 0 flagged without interrupt enable
        step("R8", 0, 1, 4'hF, 8'h02);
        step("R9", 0, 1, 4'h6, 8'hC1);          // unit 0 repeat on sec 30
        set_cur(30, 0, 0, 0, 0, 0);
        step("R9", 1, 0, 4'h7, 8'h00);          // only unit 0 fires
        step("R8", 0, 1, 4'hE, 8'hC1);          // unit 1 arm on sec 0
        set_cur(0, 0, 0, 0, 0, 0);
        step("R8", 1, 0, 4'hF, 8'h00);          // unit 1 fires, irq low
        step("R8", 0, 1, 4'hF, 8'h03);          // clear unit 1, irq high
        step("R9", 0, 0, 4'h7, 8'h00);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic       tk, we;
            logic [3:0] ad;
            logic [7:0] wd;
            for (int f = 0; f < 6; f++) cur[f] = $urandom_range(0, 2);
            tk = ($urandom_range(0, 3) != 0);
            we = ($urandom_range(0, 3) == 0);
            ad = 4'($urandom_range(0, 15));
            if (ad[2:0] < 3'd6)       wd = 8'($urandom_range(0, 2));
            else if (ad[2:0] == 3'd6) wd = {($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                                            6'($urandom_range(0, 63))};
            else                      wd = 8'($urandom_range(0, 255));
            step("R9", tk, we, ad, wd);
        end

        @(negedge clk);
        wr_en = 0; tick = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule